// File: doc/BRIEF.md
# PID-Change Page Invalidation Scanner

When the active process identifier of an address-translation unit is replaced, every translation entry that belonged only to the departing identifier must be dropped from any downstream translation cache. This block walks the entry storage one index per clock, starting at index 0. It tests each stored tag against the identifier captured at the start pulse. For every entry that is valid, not global, and owned by that identifier, it emits an invalidate request that carries the page address.

The block also accepts single-page notifications, raised when an entry is about to be overwritten. A notification turns into an invalidate request only when the new contents differ from the old ones and the old entry was valid. These requests wait in a small in-order queue. They share the same valid/ready output with the scanner and take precedence over it whenever the output register frees up.

The stored tag has this layout: the page number in bits 31..12, the global flag in bit 11, the valid flag in bit 10, and the owner identifier in bits PID_W-1..0.

Top module: `pid_inval_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it, `inv_valid_o`, `busy_o` and `done_o` are all low.
- R2: When `start_i` is high while idle, the block captures `old_pid_i` at that edge. `busy_o` goes high on the next cycle with `rd_idx_o` equal to 0.
- R3: During a scan, `rd_idx_o` steps through 0, 1, …, ENTRIES-1 in order, holding only while a matching entry waits for the output. `rd_tag_i` is expected in the same cycle as the index.
- R4: An entry is selected only when tag bit 10 is 1, tag bit 11 is 0, and tag bits PID_W-1..0 equal the captured identifier. Every selected entry yields exactly one invalidate request and no other entry yields one.
- R5: Every invalidate address is the source tag with bits 11..0 cleared.
- R6: While `inv_valid_o` is high and `inv_ready_i` is low, `inv_valid_o` and `inv_addr_o` hold their values.
- R7: `done_o` is high for exactly one cycle: the first cycle with `busy_o` low after the last entry has been checked.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The scan in progress keeps its identifier and position.
- R9: A single-page notification is queued only when `page_differ_i` is 1 and `page_old_tag_i` bit 10 is 1. Any other notification produces no request. Queued requests leave in arrival order.
- R10: When the output register is free or being emptied, a queued single-page request is loaded ahead of a pending scan match.
- R11: With the output empty and the queue empty, a notification sampled at one edge appears on `inv_valid_o` after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin a scan |
| old_pid_i | input | PID_W | Identifier being retired, sampled with start_i |
| rd_idx_o | output | IDX_W | Entry index presented to the storage read port |
| rd_tag_i | input | 32 | Tag word of the entry at rd_idx_o, same cycle |
| page_req_i | input | 1 | Single-page notification strobe |
| page_differ_i | input | 1 | New contents differ from the old ones |
| page_old_tag_i | input | 32 | Tag word about to be overwritten |
| inv_valid_o | output | 1 | Invalidate request valid |
| inv_ready_i | input | 1 | Consumer accepts the request |
| inv_addr_o | output | 32 | Page address to invalidate |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |

## Verification
The checker assumes that the entry storage does not change while a scan runs. It also assumes that single-page notifications never arrive while the queue is full, and it flags a push attempt into a full queue. The bench writes the storage only while the block is idle. It releases a notification only when its own model holds fewer than three queued entries. Consumer readiness is varied between always-ready, random, and mostly-stalled, so that stalls land both on scan matches and on queued requests.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int TAG_W      = 32;
  localparam int PAGE_BITS  = 12;
  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 11;
  localparam int VPN_W      = TAG_W - PAGE_BITS;
endpackage

// File: rtl/pis_match.sv
module pis_match
  import pis_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             hit_o,
  output logic [VPN_W-1:0] vpn_o
);
  // bits between the identifier and the valid flag carry no meaning here
  logic tag_unused;
  assign tag_unused = ^tag_i[VALID_BIT-1:PID_W];

  always_comb begin
    hit_o = tag_i[VALID_BIT] && !tag_i[GLOBAL_BIT] && (tag_i[PID_W-1:0] == pid_i);
    vpn_o = tag_i[TAG_W-1:PAGE_BITS];
  end
endmodule

// File: rtl/pis_fifo.sv
module pis_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && (wr_q == PTR_W'(g))) slot_q[g] <= data_i;
    end
  end
endmodule

// File: rtl/pis_walker.sv
module pis_walker #(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             hit_i,
  input  logic             take_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PID_W-1:0] pid_o,
  output logic             done_o
);
  logic             busy_q, busy_d, done_q, done_d, pid_en;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PID_W-1:0] pid_q;
  logic             advance, last;

  assign advance = busy_q && (!hit_i || take_i);
  assign last    = (idx_q == IDX_W'(ENTRIES - 1));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    pid_en = 1'b0;
    if (advance) begin
      if (last) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (!busy_q && start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      pid_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      pid_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      if (pid_en) pid_q <= pid_i;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign pid_o  = pid_q;
  assign done_o = done_q;
endmodule

// File: rtl/pid_inval_scanner.sv
module pid_inval_scanner
  import pis_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int QDEPTH  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PID_W-1:0] old_pid_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             page_req_i,
  input  logic             page_differ_i,
  input  logic [TAG_W-1:0] page_old_tag_i,
  output logic             inv_valid_o,
  input  logic             inv_ready_i,
  output logic [TAG_W-1:0] inv_addr_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [PID_W-1:0] scan_pid;
  logic             scan_raw, scan_hit, scan_take;
  logic [VPN_W-1:0] scan_vpn, q_head;
  logic             page_push, q_pop, q_empty, q_full;
  logic             slot_free, out_vld_q, out_vld_d, out_en;
  logic [VPN_W-1:0] out_vpn_q, out_vpn_d;
  logic             page_unused;

  assign page_unused = ^{page_old_tag_i[PAGE_BITS-1:GLOBAL_BIT], page_old_tag_i[VALID_BIT-1:0]};

  pis_match #(.PID_W(PID_W)) u_match (
    .tag_i (rd_tag_i),
    .pid_i (scan_pid),
    .hit_o (scan_raw),
    .vpn_o (scan_vpn)
  );

  pis_walker #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .pid_i   (old_pid_i),
    .hit_i   (scan_raw),
    .take_i  (scan_take),
    .busy_o  (busy_o),
    .idx_o   (rd_idx_o),
    .pid_o   (scan_pid),
    .done_o  (done_o)
  );

  assign page_push = page_req_i && page_differ_i && page_old_tag_i[VALID_BIT];

  pis_fifo #(.W(VPN_W), .DEPTH(QDEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (page_push),
    .data_i  (page_old_tag_i[TAG_W-1:PAGE_BITS]),
    .pop_i   (q_pop),
    .data_o  (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  // output register: queued single-page requests win over scan matches
  always_comb begin
    slot_free = !out_vld_q || inv_ready_i;
    scan_hit  = busy_o && scan_raw;
    q_pop     = slot_free && !q_empty;
    scan_take = slot_free && q_empty && scan_hit;
    out_en    = slot_free;
    out_vld_d = q_pop || scan_take;
    out_vpn_d = q_pop ? q_head : scan_vpn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_vpn_q <= '0;
    end else if (out_en) begin
      out_vld_q <= out_vld_d;
      if (out_vld_d) out_vpn_q <= out_vpn_d;
    end
  end

  assign inv_valid_o = out_vld_q;
  assign inv_addr_o  = {out_vpn_q, {PAGE_BITS{1'b0}}};
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             inv_valid_o,
  input logic             inv_ready_i,
  input logic [31:0]      inv_addr_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             q_push_req,
  input logic             q_full
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !inv_ready_i |=> inv_valid_o && $stable(inv_addr_o)); // R6
  AST_PAGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> inv_addr_o[11:0] == 12'h000); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R7
  AST_START_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rd_idx_o == '0); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> (rd_idx_o == $past(rd_idx_o)) ||
                                (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1))); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && (rd_idx_o != '0) |=> !busy_o || (rd_idx_o != '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push_req |-> !q_full); // R9
endmodule

bind pid_inval_scanner pis_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .inv_valid_o (inv_valid_o),
  .inv_ready_i (inv_ready_i),
  .inv_addr_o  (inv_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_idx_o    (rd_idx_o),
  .q_push_req  (page_push),
  .q_full      (q_full)
);

// File: tb/pid_inval_scanner_bench.sv
`timescale 1ns/1ps
module pid_inval_scanner_bench;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  old_pid_i = '0;
  logic [3:0]  rd_idx_o;
  logic [31:0] rd_tag_i;
  logic        page_req_i = 1'b0;
  logic        page_differ_i = 1'b0;
  logic [31:0] page_old_tag_i = '0;
  logic        inv_valid_o;
  logic        inv_ready_i = 1'b1;
  logic [31:0] inv_addr_o;
  logic        busy_o;
  logic        done_o;

  logic [31:0] mem [N];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rdy_mode = 0;

  always #5 clk_i = ~clk_i;

  assign rd_tag_i = mem[rd_idx_o];

  pid_inval_scanner u_pid_inval_scanner (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .old_pid_i(old_pid_i),
    .rd_idx_o(rd_idx_o), .rd_tag_i(rd_tag_i), .page_req_i(page_req_i),
    .page_differ_i(page_differ_i), .page_old_tag_i(page_old_tag_i),
    .inv_valid_o(inv_valid_o), .inv_ready_i(inv_ready_i), .inv_addr_o(inv_addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_done, m_ovld;
  int          m_idx;
  logic [7:0]  m_pid;
  logic [31:0] m_oaddr;
  logic [31:0] mq [$];
  int          hs_cnt = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_ovld = 0; m_idx = 0; m_pid = '0; m_oaddr = '0;
      mq.delete();
    end else begin
      bit sfree, ne, hit, take, was_busy;
      logic [31:0] t;
      if (m_ovld && inv_ready_i) hs_cnt++;
      was_busy = m_busy;
      sfree = !m_ovld || inv_ready_i;
      ne = mq.size() != 0;
      t = mem[m_idx];
      hit = m_busy && t[10] && !t[11] && (t[7:0] == m_pid);
      take = sfree && !ne && hit;
      if (sfree) begin
        if (ne) begin m_oaddr = mq.pop_front(); m_ovld = 1; end
        else if (hit) begin m_oaddr = {t[31:12], 12'h000}; m_ovld = 1; end
        else m_ovld = 0;
      end
      m_done = 0;
      if (was_busy && (!hit || take)) begin
        if (m_idx == N - 1) begin m_busy = 0; m_done = 1; m_idx = 0; end
        else m_idx++;
      end else if (!was_busy && start_i) begin
        m_busy = 1; m_idx = 0; m_pid = old_pid_i;
      end
      if (page_req_i && page_differ_i && page_old_tag_i[10])
        mq.push_back({page_old_tag_i[31:12], 12'h000});
    end
  end

  // per-cycle comparison and ready generation, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(inv_valid_o == m_ovld, "R6 R9 inv_valid", 32'(inv_valid_o), 32'(m_ovld));
      if (m_ovld) check(inv_addr_o == m_oaddr, "R5 R10 inv_addr", inv_addr_o, m_oaddr);
      check(busy_o == m_busy, "R2 R8 busy", 32'(busy_o), 32'(m_busy));
      check(done_o == m_done, "R7 done", 32'(done_o), 32'(m_done));
      if (m_busy) check(rd_idx_o == 4'(m_idx), "R3 rd_idx", 32'(rd_idx_o), 32'(m_idx));
    end
    case (rdy_mode)
      0: inv_ready_i <= 1'b1;
      1: inv_ready_i <= ($urandom % 2) == 0;
      default: inv_ready_i <= ($urandom % 5) == 0;
    endcase
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int vpn, input bit g, input bit v, input int pid);
    return {20'(vpn), g, v, 2'b00, 8'(pid)};
  endfunction

  function automatic int expect_hits(input int pid);
    int n = 0;
    for (int i = 0; i < N; i++)
      if (mem[i][10] && !mem[i][11] && mem[i][7:0] == 8'(pid)) n++;
    return n;
  endfunction

  task automatic pulse_start(input int pid);
    @(negedge clk_i); start_i = 1'b1; old_pid_i = 8'(pid);
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic page_note(input logic [31:0] tag, input bit differ);
    while (mq.size() >= 3) @(negedge clk_i);
    @(negedge clk_i); page_req_i = 1'b1; page_differ_i = differ; page_old_tag_i = tag;
    @(negedge clk_i); page_req_i = 1'b0; page_differ_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk_i);
    while ((busy_o || inv_valid_o || mq.size() != 0 || m_busy) && guard < 5000) begin
      @(negedge clk_i); guard++;
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic fill_mixed(input int seed);
    for (int i = 0; i < N; i++)
      mem[i] = mk(16'h100 * seed + i, (i % 5) == 3, (i % 7) != 6, (i % 3 == 0) ? 5 : 9);
  endtask

  initial begin
    int h0, exp;
    fill_mixed(1);
    repeat (3) @(negedge clk_i);
    // R1 reset state, while held
    check(!inv_valid_o && !busy_o && !done_o, "R1 reset outputs", {29'd0, inv_valid_o, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!inv_valid_o && !busy_o && !done_o, "R1 after release", {29'd0, inv_valid_o, busy_o, done_o}, 32'd0);

    // R4 scan with always-ready consumer
    h0 = hs_cnt; exp = expect_hits(5);
    pulse_start(5);
    check(busy_o == 1'b1 && rd_idx_o == 4'd0, "R2 busy after start", {27'd0, busy_o, rd_idx_o}, 32'h10);
    wait_idle();
    check(hs_cnt - h0 == exp, "R4 hit count pid5", 32'(hs_cnt - h0), 32'(exp));

    // R6 stalls, random ready, other identifier
    rdy_mode = 1;
    h0 = hs_cnt; exp = expect_hits(9);
    pulse_start(9);
    wait_idle();
    check(hs_cnt - h0 == exp, "R4 R6 hit count pid9", 32'(hs_cnt - h0), 32'(exp));

    // R8 start while busy with a different identifier is ignored
    for (int i = 0; i < N; i++) mem[i] = mk(i + 32'h300, 0, 1, (i < 8) ? 3 : 4);
    rdy_mode = 2;
    h0 = hs_cnt; exp = expect_hits(3);
    pulse_start(3);
    repeat (3) @(negedge clk_i);
    pulse_start(4);
    wait_idle();
    check(hs_cnt - h0 == exp, "R8 ignored restart", 32'(hs_cnt - h0), 32'(exp));

    // R9 notifications that must be dropped
    rdy_mode = 0;
    h0 = hs_cnt;
    page_note(mk(32'h777, 0, 1, 1), 1'b0);
    page_note(mk(32'h778, 0, 0, 1), 1'b1);
    repeat (4) @(negedge clk_i);
    check(!inv_valid_o && hs_cnt == h0, "R9 dropped notes", 32'(hs_cnt - h0), 32'd0);

    // R11 latency from idle
    @(negedge clk_i); page_req_i = 1'b1; page_differ_i = 1'b1; page_old_tag_i = mk(32'hABCDE, 1, 1, 2) | 32'h3FF;
    @(negedge clk_i); page_req_i = 1'b0;
    check(!inv_valid_o, "R11 not yet valid", 32'(inv_valid_o), 32'd0);
    @(negedge clk_i);
    check(inv_valid_o && inv_addr_o == 32'hABCDE000, "R11 R5 page addr", inv_addr_o, 32'hABCDE000);
    wait_idle();

    // R10 queued notes during a fully matching scan with stalled consumer
    for (int i = 0; i < N; i++) mem[i] = mk(i + 32'h500, 0, 1, 7);
    rdy_mode = 2;
    h0 = hs_cnt;
    pulse_start(7);
    page_note(mk(32'h901, 0, 1, 7), 1'b1);
    page_note(mk(32'h902, 1, 1, 0), 1'b1);
    repeat (6) @(negedge clk_i);
    page_note(mk(32'h903, 0, 1, 9), 1'b1);
    wait_idle();
    check(hs_cnt - h0 == N + 3, "R10 R9 total requests", 32'(hs_cnt - h0), 32'(N + 3));

    // randomized mix
    rdy_mode = 1;
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < N; i++)
        mem[i] = mk($urandom % 32'hFFFFF, ($urandom % 4) == 0, ($urandom % 4) != 0, $urandom % 3);
      h0 = hs_cnt; exp = expect_hits(r % 3);
      pulse_start(r % 3);
      if (r % 2 == 0) page_note(mk($urandom % 32'hFFFFF, 0, 1, 0), 1'b1);
      wait_idle();
      exp = exp + ((r % 2 == 0) ? 1 : 0);
      check(hs_cnt - h0 == exp, "R4 R9 random round", 32'(hs_cnt - h0), 32'(exp));
      rdy_mode = (r % 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule